// File: doc/BRIEF.md
# CSR access and privilege unit

This block holds the control and status registers of a 64-bit core that runs at machine, supervisor and user privilege. The pipeline presents one decoded system command per cycle: a CSR swap, set or clear (register or 5-bit immediate source), an environment call, or a supervisor return. In the same cycle the unit returns the register's old value for the destination register and decides whether the access is legal. At the next clock edge it commits the read-modify-write, or it enters a trap.

The unit stores these registers:

- a full-width scratch register;
- a status register carrying a previous-privilege field;
- a trap cause register;
- a trap PC register;
- a free-running cycle counter that cannot be written;
- a fixed ISA description word.

It also owns the current privilege level. On a trap it requests a redirect to a fixed vector. On a supervisor return it requests a redirect to the saved PC. Fetch, decode and the integer register file sit outside the block.

Top module: `csr_unit`

## Requirements
- R1: Command encoding on `cmd` is 0 none, 1 swap, 2 set, 3 clear, 4 environment call, 5 supervisor return. A legal swap raises `rd_we`, returns the old CSR value on `rd_data`, and stores the operand.
- R2: A legal set returns the old value and stores old OR operand. A legal clear returns the old value and stores old AND NOT operand.
- R3: With `use_imm` high, the operand is `src_idx` zero-extended; otherwise it is `src_val`. A set or clear whose `src_idx` is 0 (register x0 or immediate zero) leaves the CSR unchanged whatever `src_val` holds.
- R4: The scratch register (address 0x140) stores and returns all XLEN bits.
- R5: A CSR whose address bits [11:10] are 2'b11 is read-only. A swap, or a set/clear with nonzero `src_idx`, on such an address is illegal. A set/clear with `src_idx` 0 on it is legal.
- R6: An access is illegal when the current privilege is below address bits [9:8] or when the address is not implemented. An illegal command holds `rd_we` low, leaves every CSR unchanged, and raises `illegal`.
- R7: The cycle counter (address 0xC00, readable from user level) is zero at reset and advances by one on every clock.
- R8: An illegal command or an environment call takes a trap. The trap raises `redirect_valid` with `redirect_pc` = TRAP_VEC. The next cycle shows the following state:
  - the cause register (0x142) holds 2 for an illegal command, or 8 plus the current privilege for an environment call;
  - the trap PC (0x141) holds `pc` with bits [1:0] cleared;
  - the previous-privilege field holds the old privilege;
  - the privilege becomes supervisor, or stays machine if it was machine.
- R9: A supervisor return from supervisor or machine level raises `redirect_valid` with `redirect_pc` equal to the trap PC register. It sets the privilege to the previous-privilege field and resets that field to user. A return issued at user level is illegal.
- R10: Address 0x301 (machine level) reads XLEN-2 bit pair = 2'b10, bit 8 = 1, bit 18 = 1, and bit 20 = HAS_USER; writes to it are accepted and ignored.
- R11: Status (0x100) keeps the previous-privilege field in bits [1:0], encoded user 0, supervisor 1, machine 3. Writing the reserved code 2 stores user. All other status bits read 0.
- R12: After reset the privilege is machine, and scratch, status, cause and trap PC are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | System command code (R1) |
| use_imm | input | 1 | Take operand from `src_idx` instead of `src_val` |
| csr_addr | input | 12 | CSR address |
| src_idx | input | 5 | Source register index or 5-bit immediate |
| src_val | input | XLEN | Source register value |
| pc | input | XLEN | Address of the command |
| rd_we | output | 1 | Destination write enable |
| rd_data | output | XLEN | Old CSR value for the destination |
| illegal | output | 1 | Command raises an illegal-instruction trap |
| redirect_valid | output | 1 | Fetch must jump to `redirect_pc` |
| redirect_pc | output | XLEN | Trap vector or return address |
| cur_priv | output | 2 | Current privilege level |

## Verification
The bench builds the unit with XLEN and the counter width at 64 and HAS_USER at 1, so that returns into user level and the user-level privilege checks can be reached. TRAP_VEC is set to a non-default value, so that a redirect to the vector cannot match a reset or zero value by chance. The full 64-bit width lets an all-ones scratch pattern and the ISA word's top-bit field be observed. The user, supervisor and machine paths are walked in sequence, so trap entry and return are seen from every level that can issue them.

// File: rtl/csr_unit_pkg.sv
// Shared types and constants of the CSR access and privilege unit.
// Assumes a 12-bit CSR address space and the 2-bit privilege code.
package csr_unit_pkg;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_SWAP  = 3'd1,
        CMD_SET   = 3'd2,
        CMD_CLEAR = 3'd3,
        CMD_ECALL = 3'd4,
        CMD_SRET  = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_EPC,
        SEL_CAUSE,
        SEL_SCRATCH,
        SEL_CYCLE,
        SEL_ISA
    } sel_e;

    localparam logic [1:0] PRV_U = 2'd0;
    localparam logic [1:0] PRV_S = 2'd1;
    localparam logic [1:0] PRV_M = 2'd3;

    localparam logic [11:0] ADR_STATUS  = 12'h100;
    localparam logic [11:0] ADR_SCRATCH = 12'h140;
    localparam logic [11:0] ADR_EPC     = 12'h141;
    localparam logic [11:0] ADR_CAUSE   = 12'h142;
    localparam logic [11:0] ADR_ISA     = 12'h301;
    localparam logic [11:0] ADR_CYCLE   = 12'hC00;

    localparam logic [3:0] CODE_ILLEGAL    = 4'd2;
    localparam logic [3:0] CODE_ECALL_BASE = 4'd8;

    // Map a raw privilege code onto an implemented level.
    function automatic logic [1:0] legal_priv(input logic [1:0] raw, input logic has_user);
        logic [1:0] r;
        r = (raw == 2'b10) ? PRV_U : raw;
        if (r == PRV_U && !has_user) r = PRV_S;
        return r;
    endfunction

endpackage

// File: rtl/csr_access_check.sv
// Decodes the CSR address and judges whether the command is legal.
// Assumes the command is presented for one cycle; purely combinational.
module csr_access_check
    import csr_unit_pkg::*;
(
    input  cmd_e        cmd,
    input  logic [11:0] addr,
    input  logic [4:0]  src_idx,
    input  logic [1:0]  priv,
    output sel_e        sel,
    output logic        is_csr,
    output logic        is_ecall,
    output logic        is_sret,
    output logic        wr_intent,
    output logic        illegal
);

    logic priv_ok;
    logic read_only;
    logic csr_bad;
    logic sret_bad;

    // Map the address onto a storage selector.
    always_comb begin
        unique case (addr)
            ADR_STATUS:  sel = SEL_STATUS;
            ADR_SCRATCH: sel = SEL_SCRATCH;
            ADR_EPC:     sel = SEL_EPC;
            ADR_CAUSE:   sel = SEL_CAUSE;
            ADR_ISA:     sel = SEL_ISA;
            ADR_CYCLE:   sel = SEL_CYCLE;
            default:     sel = SEL_NONE;
        endcase
    end

    // Classify the command and apply the privilege and write rules.
    always_comb begin
        is_csr    = (cmd == CMD_SWAP) || (cmd == CMD_SET) || (cmd == CMD_CLEAR);
        is_ecall  = (cmd == CMD_ECALL);
        is_sret   = (cmd == CMD_SRET);
        wr_intent = is_csr && ((cmd == CMD_SWAP) || (src_idx != 5'd0));
        priv_ok   = (priv >= addr[9:8]);
        read_only = (addr[11:10] == 2'b11);
        csr_bad   = is_csr && ((sel == SEL_NONE) || !priv_ok || (read_only && wr_intent));
        sret_bad  = is_sret && (priv < PRV_S);
        illegal   = csr_bad || sret_bad;
    end

endmodule

// File: rtl/csr_rmw_alu.sv
// Computes the value a swap, set or clear would store.
// Assumes the caller gates the result with the write decision.
module csr_rmw_alu
    import csr_unit_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  cmd_e            cmd,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] new_val
);

    // Select the read-modify-write combination.
    always_comb begin
        unique case (cmd)
            CMD_SWAP:  new_val = operand;
            CMD_SET:   new_val = old_val | operand;
            CMD_CLEAR: new_val = old_val & ~operand;
            default:   new_val = old_val;
        endcase
    end

endmodule

// File: rtl/csr_state.sv
// Holds the CSRs, the cycle counter and the privilege level.
// Assumes at most one of trap_en, sret_en, wr_en acts per cycle; a trap wins.
module csr_state
    import csr_unit_pkg::*;
#(
    parameter int              XLEN     = 64,
    parameter int              CNT_W    = 64,
    parameter bit              HAS_USER = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  sel_e            sel,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_val,
    input  logic            trap_en,
    input  logic [3:0]      trap_code,
    input  logic [XLEN-1:0] pc,
    input  logic            sret_en,
    output logic [XLEN-1:0] rd_val,
    output logic [1:0]      priv,
    output logic [1:0]      prev_priv,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] cause,
    output logic [CNT_W-1:0] cycles
);

    localparam logic [XLEN-1:0] ISA_VAL =
        (XLEN'(2) << (XLEN - 2)) |
        (XLEN'(1) << 8) |
        (XLEN'(1) << 18) |
        (XLEN'(HAS_USER ? 1 : 0) << 20);
    localparam logic [1:0] RET_DEFAULT = HAS_USER ? PRV_U : PRV_S;

    logic [XLEN-1:0] scratch;

    // Free-running cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cycles <= '0;
        else        cycles <= cycles + 1'b1;
    end

    // Privilege level and previous-privilege field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv      <= PRV_M;
            prev_priv <= PRV_U;
        end else if (trap_en) begin
            prev_priv <= priv;
            priv      <= (priv == PRV_M) ? PRV_M : PRV_S;
        end else if (sret_en) begin
            priv      <= prev_priv;
            prev_priv <= RET_DEFAULT;
        end else if (wr_en && sel == SEL_STATUS) begin
            prev_priv <= legal_priv(wr_val[1:0], HAS_USER);
        end
    end

    // Trap cause and trap PC registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
            epc   <= '0;
        end else if (trap_en) begin
            cause <= XLEN'(trap_code);
            epc   <= pc & ~XLEN'(3);
        end else if (wr_en) begin
            if (sel == SEL_CAUSE) cause <= wr_val;
            if (sel == SEL_EPC)   epc   <= wr_val & ~XLEN'(3);
        end
    end

    // Scratch register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  scratch <= '0;
        else if (wr_en && !trap_en && sel == SEL_SCRATCH) scratch <= wr_val;
    end

    // Read multiplexer for the old value.
    always_comb begin
        unique case (sel)
            SEL_STATUS:  rd_val = XLEN'(prev_priv);
            SEL_SCRATCH: rd_val = scratch;
            SEL_EPC:     rd_val = epc;
            SEL_CAUSE:   rd_val = cause;
            SEL_ISA:     rd_val = ISA_VAL;
            SEL_CYCLE:   rd_val = XLEN'(cycles);
            default:     rd_val = '0;
        endcase
    end

endmodule

// File: rtl/csr_unit.sv
// Top of the CSR access and privilege unit: operand selection, legality,
// read-modify-write commit, trap entry and supervisor return.
// Assumes CNT_W <= XLEN and one decoded command per cycle.
module csr_unit
    import csr_unit_pkg::*;
#(
    parameter int              XLEN     = 64,
    parameter int              CNT_W    = 64,
    parameter bit              HAS_USER = 1'b1,
    parameter logic [63:0]     TRAP_VEC = 64'h0000_0000_0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      cmd,
    input  logic            use_imm,
    input  logic [11:0]     csr_addr,
    input  logic [4:0]      src_idx,
    input  logic [XLEN-1:0] src_val,
    input  logic [XLEN-1:0] pc,
    output logic            rd_we,
    output logic [XLEN-1:0] rd_data,
    output logic            illegal,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [1:0]      cur_priv
);

    cmd_e            cmd_q;
    sel_e            sel;
    logic            is_csr;
    logic            is_ecall;
    logic            is_sret;
    logic            wr_intent;
    logic            bad;
    logic [XLEN-1:0] operand;
    logic [XLEN-1:0] old_val;
    logic [XLEN-1:0] new_val;
    logic            wr_en;
    logic            trap_en;
    logic            sret_en;
    logic [3:0]      trap_code;
    logic [1:0]      prev_w;
    logic [XLEN-1:0] epc_w;
    logic [XLEN-1:0] cause_w;
    logic [CNT_W-1:0] cycles_w;

    assign cmd_q = cmd_e'(cmd);

    csr_access_check chk_u (
        .cmd      (cmd_q),
        .addr     (csr_addr),
        .src_idx  (src_idx),
        .priv     (cur_priv),
        .sel      (sel),
        .is_csr   (is_csr),
        .is_ecall (is_ecall),
        .is_sret  (is_sret),
        .wr_intent(wr_intent),
        .illegal  (bad)
    );

    csr_rmw_alu #(.XLEN(XLEN)) alu_u (
        .cmd    (cmd_q),
        .old_val(old_val),
        .operand(operand),
        .new_val(new_val)
    );

    csr_state #(.XLEN(XLEN), .CNT_W(CNT_W), .HAS_USER(HAS_USER)) st_u (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .wr_en    (wr_en),
        .wr_val   (new_val),
        .trap_en  (trap_en),
        .trap_code(trap_code),
        .pc       (pc),
        .sret_en  (sret_en),
        .rd_val   (old_val),
        .priv     (cur_priv),
        .prev_priv(prev_w),
        .epc      (epc_w),
        .cause    (cause_w),
        .cycles   (cycles_w)
    );

    // Operand source and commit decisions.
    always_comb begin
        operand   = use_imm ? XLEN'(src_idx) : src_val;
        wr_en     = is_csr && wr_intent && !bad;
        trap_en   = bad || is_ecall;
        sret_en   = is_sret && !bad;
        trap_code = is_ecall ? (CODE_ECALL_BASE + 4'(cur_priv)) : CODE_ILLEGAL;
    end

    // Outputs toward the register file and fetch.
    always_comb begin
        illegal        = bad;
        rd_we          = is_csr && !bad;
        rd_data        = rd_we ? old_val : '0;
        redirect_valid = trap_en || sret_en;
        redirect_pc    = trap_en ? XLEN'(TRAP_VEC) : epc_w;
    end

endmodule

// File: rtl/csr_unit_chk.sv
// Temporal checks on the CSR unit, attached by bind.
module csr_unit_chk #(
    parameter int XLEN  = 64,
    parameter int CNT_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      cmd,
    input logic [11:0]     csr_addr,
    input logic [4:0]      src_idx,
    input logic [XLEN-1:0] pc,
    input logic            illegal,
    input logic            rd_we,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic [1:0]      cur_priv,
    input logic [1:0]      prev_w,
    input logic [XLEN-1:0] epc_w,
    input logic [XLEN-1:0] cause_w,
    input logic [CNT_W-1:0] cycles_w
);

    logic csr_cmd;
    assign csr_cmd = (cmd == 3'd1) || (cmd == 3'd2) || (cmd == 3'd3);

    AST_RO_WRITE_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_cmd && csr_addr[11:10] == 2'b11 && (cmd == 3'd1 || src_idx != 5'd0)) |-> illegal); // R5

    AST_NO_RD_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !rd_we); // R6

    AST_USER_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_cmd && cur_priv == 2'd0 && csr_addr == 12'h100) |-> illegal); // R6

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cycles_w == CNT_W'($past(cycles_w) + 1'b1)); // R7

    AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> cause_w == XLEN'(2)); // R8

    AST_TRAP_EPC: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> epc_w == ($past(pc) & ~XLEN'(3))); // R8

    AST_ECALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd4) |=> cause_w == XLEN'(4'd8 + 4'($past(cur_priv)))); // R8

    AST_SRET_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd5 && !illegal) |=> cur_priv == $past(prev_w)); // R9

    AST_SRET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd5 && !illegal) |-> (redirect_valid && redirect_pc == epc_w)); // R9

endmodule

bind csr_unit csr_unit_chk #(.XLEN(XLEN), .CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd           (cmd),
    .csr_addr      (csr_addr),
    .src_idx       (src_idx),
    .pc            (pc),
    .illegal       (illegal),
    .rd_we         (rd_we),
    .redirect_valid(redirect_valid),
    .redirect_pc   (redirect_pc),
    .cur_priv      (cur_priv),
    .prev_w        (prev_w),
    .epc_w         (epc_w),
    .cause_w       (cause_w),
    .cycles_w      (cycles_w)
);

// File: tb/csr_unit_tb_top.sv
`timescale 1ns/1ps
module csr_unit_tb_top;

    localparam int          XLEN = 64;
    localparam logic [63:0] TVEC = 64'h0000_0000_8000_0040;
    localparam logic [63:0] ISA  = 64'h8000_0000_0014_0100;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic [2:0]  cmd;
        logic        imm;
        logic [11:0] addr;
        logic [4:0]  src;
        logic [63:0] val;
        logic        ill;
        logic        chk;
        logic [63:0] rd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 1'b1, 12'h140, 5'd3,  64'd0,         1'b0, 1'b1, 64'd0,         8'd1},  // R1
        '{3'd2, 1'b0, 12'h140, 5'd0,  64'd0,         1'b0, 1'b1, 64'd3,         8'd3},  // R3
        '{3'd3, 1'b1, 12'h140, 5'd1,  64'd0,         1'b0, 1'b1, 64'd3,         8'd3},  // R3
        '{3'd2, 1'b1, 12'h140, 5'd4,  64'd0,         1'b0, 1'b1, 64'd2,         8'd3},  // R3
        '{3'd1, 1'b1, 12'h140, 5'd2,  64'd0,         1'b0, 1'b1, 64'd6,         8'd1},  // R1
        '{3'd1, 1'b0, 12'h140, 5'd10, 64'h0bad1dea,  1'b0, 1'b1, 64'd2,         8'd4},  // R4
        '{3'd3, 1'b0, 12'h140, 5'd10, 64'h00001dea,  1'b0, 1'b1, 64'h0bad1dea,  8'd2},  // R2
        '{3'd2, 1'b0, 12'h140, 5'd10, 64'h0000beef,  1'b0, 1'b1, 64'h0bad0000,  8'd2},  // R2
        '{3'd2, 1'b0, 12'h140, 5'd0,  64'd0,         1'b0, 1'b1, 64'h0badbeef,  8'd4},  // R4
        '{3'd1, 1'b0, 12'h140, 5'd10, ONES,          1'b0, 1'b1, 64'h0badbeef,  8'd4},  // R4
        '{3'd3, 1'b0, 12'h140, 5'd0,  ONES,          1'b0, 1'b1, ONES,          8'd3},  // R3
        '{3'd2, 1'b0, 12'h140, 5'd0,  64'd0,         1'b0, 1'b1, ONES,          8'd3},  // R3
        '{3'd1, 1'b0, 12'hC00, 5'd7,  64'd0,         1'b1, 1'b0, 64'd0,         8'd5},  // R5
        '{3'd2, 1'b1, 12'hC00, 5'd0,  64'd0,         1'b0, 1'b0, 64'd0,         8'd5},  // R5
        '{3'd2, 1'b1, 12'hC00, 5'd5,  64'd0,         1'b1, 1'b0, 64'd0,         8'd5},  // R5
        '{3'd2, 1'b0, 12'h301, 5'd0,  64'd0,         1'b0, 1'b1, ISA,           8'd10}, // R10
        '{3'd1, 1'b0, 12'h301, 5'd7,  64'd0,         1'b0, 1'b1, ISA,           8'd10}, // R10
        '{3'd2, 1'b0, 12'h301, 5'd0,  64'd0,         1'b0, 1'b1, ISA,           8'd10}, // R10
        '{3'd2, 1'b0, 12'h7FF, 5'd0,  64'd0,         1'b1, 1'b0, 64'd0,         8'd6}   // R6
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      cmd = '0;
    logic            use_imm = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [4:0]      src_idx = '0;
    logic [XLEN-1:0] src_val = '0;
    logic [XLEN-1:0] pc = '0;
    logic            rd_we;
    logic [XLEN-1:0] rd_data;
    logic            illegal;
    logic            redirect_valid;
    logic [XLEN-1:0] redirect_pc;
    logic [1:0]      cur_priv;

    int n_tests = 0;
    int n_fail  = 0;
    logic            s_we, s_ill, s_rv;
    logic [XLEN-1:0] s_rd, s_rpc;

    always #4 clk = ~clk;

    csr_unit #(.XLEN(XLEN), .CNT_W(64), .HAS_USER(1'b1), .TRAP_VEC(TVEC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .use_imm(use_imm), .csr_addr(csr_addr),
        .src_idx(src_idx), .src_val(src_val), .pc(pc), .rd_we(rd_we), .rd_data(rd_data),
        .illegal(illegal), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .cur_priv(cur_priv)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one command at the falling edge, sample, cross one rising edge.
    task automatic op(input logic [2:0] c, input logic im, input logic [11:0] a,
                      input logic [4:0] s, input logic [63:0] v, input logic [63:0] p);
        cmd = c; use_imm = im; csr_addr = a; src_idx = s; src_val = v; pc = p;
        #1;
        s_we = rd_we; s_ill = illegal; s_rd = rd_data; s_rv = redirect_valid; s_rpc = redirect_pc;
        @(posedge clk);
        @(negedge clk);
        cmd = 3'd0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [63:0] c1;
        idle(2);
        rst_n = 1'b1;
        check("R12 reset privilege", 64'(cur_priv), 64'd3);
        op(3'd2, 1'b0, 12'h142, 5'd0, 0, 64'h100);
        check("R12 reset cause", s_rd, 64'd0);

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].cmd, VECS[i].imm, VECS[i].addr, VECS[i].src, VECS[i].val, 64'h1000 + 64'(4 * i));
            check($sformatf("R%0d vec %0d illegal", VECS[i].req, i), 64'(s_ill), 64'(VECS[i].ill));
            check($sformatf("R%0d vec %0d rd_we", VECS[i].req, i), 64'(s_we), 64'(!VECS[i].ill));
            if (VECS[i].chk)
                check($sformatf("R%0d vec %0d rd_data", VECS[i].req, i), s_rd, VECS[i].rd);
        end

        // R9: return from machine level into user level
        op(3'd1, 1'b0, 12'h141, 5'd9, 64'h2000, 64'h1100);
        op(3'd1, 1'b0, 12'h100, 5'd9, 64'd0, 64'h1104);
        op(3'd5, 1'b0, 12'h000, 5'd0, 64'd0, 64'h1108);
        check("R9 sret redirect", 64'(s_rv), 64'd1);
        check("R9 sret target", s_rpc, 64'h2000);
        check("R9 sret enters user", 64'(cur_priv), 64'd0);

        // R6/R8: user read of status traps into supervisor
        op(3'd2, 1'b0, 12'h100, 5'd0, 64'd0, 64'h2000);
        check("R6 user status read illegal", 64'(s_ill), 64'd1);
        check("R6 user status no rd_we", 64'(s_we), 64'd0);
        check("R8 trap vector", s_rpc, TVEC);
        check("R8 trap enters supervisor", 64'(cur_priv), 64'd1);
        op(3'd2, 1'b0, 12'h142, 5'd0, 64'd0, TVEC);
        check("R8 illegal cause", s_rd, 64'd2);
        op(3'd2, 1'b0, 12'h141, 5'd0, 64'd0, TVEC);
        check("R8 trap pc", s_rd, 64'h2000);
        op(3'd2, 1'b0, 12'h100, 5'd0, 64'd0, TVEC);
        check("R11 previous privilege user", s_rd, 64'd0);

        // R8: trap PC low bits forced to zero; return past the faulting command
        op(3'd1, 1'b0, 12'h141, 5'd9, 64'h2007, TVEC);
        op(3'd2, 1'b0, 12'h141, 5'd0, 64'd0, TVEC);
        check("R8 trap pc alignment", s_rd, 64'h2004);
        op(3'd5, 1'b0, 12'h000, 5'd0, 64'd0, TVEC);
        check("R9 return target", s_rpc, 64'h2004);
        check("R9 return to user", 64'(cur_priv), 64'd0);

        // R5/R7: user counter write traps, reads advance by elapsed clocks
        op(3'd1, 1'b0, 12'hC00, 5'd3, 64'hFF, 64'h2004);
        check("R5 user cycle write illegal", 64'(s_ill), 64'd1);
        check("R5 user cycle write no rd_we", 64'(s_we), 64'd0);
        op(3'd5, 1'b0, 12'h000, 5'd0, 64'd0, TVEC);
        check("R9 back to user", 64'(cur_priv), 64'd0);
        op(3'd2, 1'b0, 12'hC00, 5'd0, 64'd0, 64'h2008);
        check("R7 user cycle read legal", 64'(s_we), 64'd1);
        c1 = s_rd;
        idle(3);
        op(3'd2, 1'b1, 12'hC00, 5'd0, 64'd0, 64'h200C);
        check("R7 cycle step", s_rd - c1, 64'd4);

        // R8: environment call from user level
        op(3'd4, 1'b0, 12'h000, 5'd0, 64'd0, 64'h2010);
        check("R8 ecall vector", s_rpc, TVEC);
        check("R8 ecall to supervisor", 64'(cur_priv), 64'd1);
        op(3'd2, 1'b0, 12'h142, 5'd0, 64'd0, TVEC);
        check("R8 user ecall cause", s_rd, 64'd8);

        // R6: supervisor cannot reach the machine-level ISA word
        op(3'd2, 1'b0, 12'h301, 5'd0, 64'd0, 64'h3000);
        check("R6 supervisor isa illegal", 64'(s_ill), 64'd1);
        check("R8 supervisor stays supervisor", 64'(cur_priv), 64'd1);
        op(3'd2, 1'b0, 12'h100, 5'd0, 64'd0, TVEC);
        check("R11 previous privilege supervisor", s_rd, 64'd1);

        // R11: status field legalisation
        op(3'd1, 1'b0, 12'h100, 5'd9, 64'd2, TVEC);
        op(3'd2, 1'b0, 12'h100, 5'd0, 64'd0, TVEC);
        check("R11 reserved code stores user", s_rd, 64'd0);
        op(3'd1, 1'b0, 12'h100, 5'd9, 64'd5, TVEC);
        op(3'd2, 1'b0, 12'h100, 5'd0, 64'd0, TVEC);
        check("R11 upper status bits zero", s_rd, 64'd1);
        op(3'd5, 1'b0, 12'h000, 5'd0, 64'd0, TVEC);
        check("R9 return to supervisor", 64'(cur_priv), 64'd1);
        op(3'd2, 1'b0, 12'h100, 5'd0, 64'd0, TVEC);
        check("R9 field reset to user", s_rd, 64'd0);

        // R9: return issued at user level is illegal
        op(3'd5, 1'b0, 12'h000, 5'd0, 64'd0, TVEC);
        check("R9 enter user", 64'(cur_priv), 64'd0);
        op(3'd5, 1'b0, 12'h000, 5'd0, 64'd0, 64'h4000);
        check("R9 user return illegal", 64'(s_ill), 64'd1);
        check("R9 user return traps", s_rpc, TVEC);
        op(3'd2, 1'b0, 12'h142, 5'd0, 64'd0, TVEC);
        check("R9 user return cause", s_rd, 64'd2);

        // R12: reset in the middle of a run
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        check("R12 privilege after reset", 64'(cur_priv), 64'd3);
        op(3'd2, 1'b0, 12'h140, 5'd0, 64'd0, 64'h100);
        check("R12 scratch after reset", s_rd, 64'd0);
        op(3'd2, 1'b0, 12'h141, 5'd0, 64'd0, 64'h104);
        check("R12 trap pc after reset", s_rd, 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule